// File: doc/BRIEF.md
# Accumulator ALU with Per-Operation Flag Rules

This block is the combinational arithmetic and logic core of a small accumulator processor. A decoder presents an operation code, one or two operands and the current condition bits (half-carry, negative, zero, overflow, carry). In the same cycle the block returns a result, a write strobe for the destination register, the next N, Z, V and C bits, and a four-bit mask that shows which of those bits the operation changed. The operations are clear, ones complement, decrement by one, exclusive OR, an 8-bit compare, a 16-bit compare and a decimal adjust of a binary sum to packed BCD.

Each operation has its own flag rule. Some flags are forced to constants, some come from the result, and some pass through unchanged. The two compares produce flags only and do not assert the write strobe. Fetch, addressing, the register file and cycle timing belong to the surrounding core.

Top module: `accu_alu`

## Requirements
- R1: `op_sel` encodes 0=clear, 1=complement, 2=decrement, 3=exclusive OR, 4=byte compare, 5=word compare, 6=decimal adjust, 7=no operation. `cc_in` holds H,N,Z,V,C in bits 4..0. `flag_upd` marks N,Z,V,C in bits 3..0. Byte operations use and produce bits 7:0 only, with `result[15:8]` zero.
- R2: Clear writes 0x00 and sets N=0, Z=1, V=0, C=0, with mask 1111.
- R3: Complement writes 0xFF minus `opnd_a[7:0]`. N and Z follow the result, V=0 and C=1, with mask 1111.
- R4: Decrement writes `opnd_a[7:0]` minus 1. N and Z follow the result, and V is set only when the operand was 0x80. C equals the incoming C, with mask 1110.
- R5: Exclusive OR writes `opnd_a[7:0]` XOR `opnd_m[7:0]`. N and Z follow the result, V=0, C is held, with mask 1110.
- R6: The byte compare forms `opnd_a[7:0]` minus `opnd_m[7:0]` and drives that difference on `result[7:0]` with `res_we` low. C is the borrow. V is set when the operand signs differ and the difference sign differs from the minuend sign. The mask is 1111.
- R7: The word compare subtracts `opnd_m` from `opnd_a` over 16 bits. The high byte of `opnd_m` is the byte from the lower address. It sets N, Z, V and C by the R6 rules at 16 bits and keeps `res_we` low.
- R8: Decimal adjust adds 0x06 when the low nibble of `opnd_a[7:0]` exceeds 9 or H is set. It also adds 0x60 when bits 8:4 of the low-corrected 9-bit sum exceed 9 or C is set. The sum is written.
- R9: After decimal adjust, C is the incoming C OR the high correction, and N and Z follow the result. V is set when the operand's bit 7 is clear and the result's bit 7 is set. The mask is 1111.
- R10: No-operation drives `result` to zero with `res_we` low and mask 0000, and passes N, Z, V, C through.
- R11: Any flag whose mask bit is clear equals the corresponding `cc_in` bit.
- R12: Whenever `res_we` is high, `z_out` is 1 exactly when `result[7:0]` is zero, and `n_out` equals `result[7]`.
- R13: All outputs are a combinational function of the present inputs, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code |
| opnd_a | input | 16 | Register operand (accumulator or 16-bit register) |
| opnd_m | input | 16 | Memory operand; high byte from lower address |
| cc_in | input | 5 | Present H,N,Z,V,C |
| result | output | 16 | Computed value |
| res_we | output | 1 | Destination write strobe |
| flag_upd | output | 4 | N,Z,V,C changed-by-operation mask |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| v_out | output | 1 | Next overflow flag |
| c_out | output | 1 | Next carry flag |

## Verification
Every output is due in the same cycle that its inputs change, with no register on any path. The bench therefore drives a vector on the falling clock edge and compares all outputs a quarter period later, before the next rising edge. It never waits on a clock to see a result. Each vector is compared as one packed word against a model in the bench that is written from the flag rules above. The vectors cover the signed-overflow, borrow, zero and nibble-carry corners.

// File: rtl/accu_alu_pkg.sv
// Package: shared operation codes and flag bundle for the accumulator ALU.
// Assumes the code values are fixed by the instruction decoder upstream.
package accu_alu_pkg;
    typedef enum logic [2:0] {
        OP_CLR   = 3'd0,
        OP_COM   = 3'd1,
        OP_DEC   = 3'd2,
        OP_XOR   = 3'd3,
        OP_CMP8  = 3'd4,
        OP_CMP16 = 3'd5,
        OP_DAA   = 3'd6,
        OP_NOP   = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

    localparam logic [3:0] UPD_ALL  = 4'b1111;
    localparam logic [3:0] UPD_NZV  = 4'b1110;
    localparam logic [3:0] UPD_NONE = 4'b0000;
endpackage

// File: rtl/alu_logic_unit.sv
// Module: bitwise part of the ALU - clear, ones complement, exclusive OR.
// Assumes op is one of the codes in accu_alu_pkg; other codes give zero.
module alu_logic_unit
    import accu_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   m,
    output logic [DW-1:0]   res
);
    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

    // Select the bitwise function for the current code.
    always_comb begin
        unique case (op)
            OP_COM:  res = ALL_ONES - a;
            OP_XOR:  res = a ^ m;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_sub_unit.sv
// Module: W-bit subtractor producing difference and N, Z, V, C.
// Assumes unsigned borrow semantics for C and two's complement for V.
module alu_sub_unit
    import accu_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] diff,
    output nzvc_t        flags
);
    logic borrow;

    // Form the difference together with the borrow out of the top bit.
    always_comb begin
        {borrow, diff} = {1'b0, a} - {1'b0, b};
    end

    // Derive the four condition bits from operands and difference.
    always_comb begin
        flags.n = diff[W-1];
        flags.z = (diff == '0);
        flags.v = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
        flags.c = borrow;
    end
endmodule

// File: rtl/alu_bcd_adjust.sv
// Module: corrects a binary sum of two BCD bytes into packed BCD.
// Assumes an 8-bit accumulator; H and C are the flags from the prior add.
module alu_bcd_adjust
    import accu_alu_pkg::*;
#(
    parameter int NIB = 4
) (
    input  logic [2*NIB-1:0] a,
    input  logic             h_in,
    input  logic             c_in,
    output logic [2*NIB-1:0] res,
    output nzvc_t            flags
);
    localparam int BW = 2 * NIB;
    localparam logic [NIB-1:0] DEC_MAX = NIB'(9);
    localparam logic [NIB-1:0] FIX     = NIB'(6);

    logic          lo_fix;
    logic          hi_fix;
    logic [BW:0]   part_sum;
    logic [BW-1:0] corr;

    // Decide the low-nibble correction and the resulting partial sum.
    always_comb begin
        lo_fix   = (a[NIB-1:0] > DEC_MAX) | h_in;
        part_sum = {1'b0, a} + (lo_fix ? (BW+1)'(FIX) : '0);
    end

    // Decide the high-nibble correction from the partial sum and carry.
    always_comb begin
        hi_fix = (part_sum[BW:NIB] > (NIB+1)'(DEC_MAX)) | c_in;
        corr   = {(hi_fix ? FIX : '0), (lo_fix ? FIX : '0)};
        res    = a + corr;
    end

    // Produce the flags of the adjusted value.
    always_comb begin
        flags.n = res[BW-1];
        flags.z = (res == '0);
        flags.v = ~a[BW-1] & res[BW-1];
        flags.c = c_in | hi_fix;
    end
endmodule

// File: rtl/accu_alu.sv
// Module: top of the accumulator ALU. Selects the active sub-unit, the
// write strobe and the flag-update mask, then merges masked flags with
// the incoming ones. Purely combinational; assumes DW is 8 for the
// decimal adjust path, which acts on the low byte.
module accu_alu
    import accu_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2:0]      op_sel,
    input  logic [2*DW-1:0] opnd_a,
    input  logic [2*DW-1:0] opnd_m,
    input  logic [4:0]      cc_in,
    output logic [2*DW-1:0] result,
    output logic            res_we,
    output logic [3:0]      flag_upd,
    output logic            n_out,
    output logic            z_out,
    output logic            v_out,
    output logic            c_out
);
    localparam int WW = 2 * DW;
    localparam int NF = 4;

    alu_op_e       op;
    logic          h_in;
    nzvc_t         held;
    nzvc_t         nf;
    logic [DW-1:0] lu_res;
    logic [DW-1:0] sb_b;
    logic [DW-1:0] sb_diff;
    nzvc_t         sb_f;
    logic [WW-1:0] sw_diff;
    nzvc_t         sw_f;
    logic [DW-1:0] da_res;
    nzvc_t         da_f;
    logic [NF-1:0] nf_bits;
    logic [NF-1:0] held_bits;
    logic [NF-1:0] out_bits;

    assign op   = alu_op_e'(op_sel);
    assign h_in = cc_in[4];
    assign held = nzvc_t'(cc_in[3:0]);

    alu_logic_unit #(.DW(DW)) u_logic (
        .op  (op),
        .a   (opnd_a[DW-1:0]),
        .m   (opnd_m[DW-1:0]),
        .res (lu_res)
    );

    // Decrement reuses the byte subtractor with a constant one.
    assign sb_b = (op == OP_DEC) ? DW'(1) : opnd_m[DW-1:0];

    alu_sub_unit #(.W(DW)) u_sub_byte (
        .a     (opnd_a[DW-1:0]),
        .b     (sb_b),
        .diff  (sb_diff),
        .flags (sb_f)
    );

    alu_sub_unit #(.W(WW)) u_sub_word (
        .a     (opnd_a),
        .b     (opnd_m),
        .diff  (sw_diff),
        .flags (sw_f)
    );

    alu_bcd_adjust #(.NIB(DW/2)) u_bcd (
        .a     (opnd_a[DW-1:0]),
        .h_in  (h_in),
        .c_in  (held.c),
        .res   (da_res),
        .flags (da_f)
    );

    // Route the chosen result, strobe, mask and candidate flags.
    always_comb begin
        result   = '0;
        res_we   = 1'b0;
        flag_upd = UPD_NONE;
        nf       = held;
        unique case (op)
            OP_CLR: begin
                result[DW-1:0] = lu_res;
                res_we         = 1'b1;
                flag_upd       = UPD_ALL;
                nf             = '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
            end
            OP_COM: begin
                result[DW-1:0] = lu_res;
                res_we         = 1'b1;
                flag_upd       = UPD_ALL;
                nf.n           = lu_res[DW-1];
                nf.z           = (lu_res == '0);
                nf.v           = 1'b0;
                nf.c           = 1'b1;
            end
            OP_DEC: begin
                result[DW-1:0] = sb_diff;
                res_we         = 1'b1;
                flag_upd       = UPD_NZV;
                nf.n           = sb_f.n;
                nf.z           = sb_f.z;
                nf.v           = sb_f.v;
            end
            OP_XOR: begin
                result[DW-1:0] = lu_res;
                res_we         = 1'b1;
                flag_upd       = UPD_NZV;
                nf.n           = lu_res[DW-1];
                nf.z           = (lu_res == '0);
                nf.v           = 1'b0;
            end
            OP_CMP8: begin
                result[DW-1:0] = sb_diff;
                flag_upd       = UPD_ALL;
                nf             = sb_f;
            end
            OP_CMP16: begin
                result   = sw_diff;
                flag_upd = UPD_ALL;
                nf       = sw_f;
            end
            OP_DAA: begin
                result[DW-1:0] = da_res;
                res_we         = 1'b1;
                flag_upd       = UPD_ALL;
                nf             = da_f;
            end
            default: begin
                result = '0;
            end
        endcase
    end

    assign nf_bits   = nf;
    assign held_bits = held;

    // Per-flag merge: take the new bit only where the mask allows.
    for (genvar i = 0; i < NF; i++) begin : g_flag_merge
        assign out_bits[i] = flag_upd[i] ? nf_bits[i] : held_bits[i];
    end

    assign n_out = out_bits[3];
    assign z_out = out_bits[2];
    assign v_out = out_bits[1];
    assign c_out = out_bits[0];
endmodule

// File: rtl/accu_alu_chk.sv
// Module: property checker for accu_alu, attached by bind. The block has
// no clock, so checks are immediate assertions on settled inputs.
module accu_alu_chk #(
    parameter int DW = 8
) (
    input logic [2:0]      op_sel,
    input logic [2*DW-1:0] opnd_a,
    input logic [2*DW-1:0] opnd_m,
    input logic [4:0]      cc_in,
    input logic [2*DW-1:0] result,
    input logic            res_we,
    input logic [3:0]      flag_upd,
    input logic            n_out,
    input logic            z_out,
    input logic            v_out,
    input logic            c_out
);
    // Evaluate every rule whenever any port changes.
    always_comb begin
        if (op_sel == 3'd0) begin
            AST_CLEAR_FLAGS: assert (result == '0 && !n_out && z_out && !v_out && !c_out) // R2
                else $error("clear flags wrong");
        end
        if (op_sel == 3'd1) begin
            AST_COM_CARRY: assert (c_out && !v_out && res_we) // R3
                else $error("complement carry wrong");
        end
        if (op_sel == 3'd2) begin
            AST_DEC_KEEPS_C: assert (c_out == cc_in[0]) // R4
                else $error("decrement touched carry");
        end
        if (op_sel == 3'd3) begin
            AST_XOR_KEEPS_C: assert (c_out == cc_in[0] && !v_out) // R5
                else $error("xor carry or overflow wrong");
        end
        if (op_sel == 3'd4 || op_sel == 3'd5) begin
            AST_CMP_NO_WRITE: assert (!res_we) // R6
                else $error("compare wrote result");
        end
        if (op_sel == 3'd7) begin
            AST_NOP_HOLDS: assert (!res_we && {n_out, z_out, v_out, c_out} == cc_in[3:0]) // R10
                else $error("no-op changed state");
        end
        if (res_we) begin
            AST_ZERO_MATCH: assert (z_out == (result[DW-1:0] == '0) && n_out == result[DW-1]) // R12
                else $error("N/Z inconsistent with written result");
        end
    end
endmodule

bind accu_alu accu_alu_chk #(.DW(DW)) u_chk (
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_m   (opnd_m),
    .cc_in    (cc_in),
    .result   (result),
    .res_we   (res_we),
    .flag_upd (flag_upd),
    .n_out    (n_out),
    .z_out    (z_out),
    .v_out    (v_out),
    .c_out    (c_out)
);

// File: tb/tb_accu_alu.sv
// Directed bench for accu_alu: one task per scenario, each checking its
// own vectors against a model written from the requirements.
module tb_accu_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = 3'd7;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_m = '0;
    logic [4:0]  cc_in = '0;
    logic [15:0] result;
    logic        res_we;
    logic [3:0]  flag_upd;
    logic        n_out, z_out, v_out, c_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    accu_alu dut (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_m(opnd_m), .cc_in(cc_in),
        .result(result), .res_we(res_we), .flag_upd(flag_upd),
        .n_out(n_out), .z_out(z_out), .v_out(v_out), .c_out(c_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model: returns {result16, we, mask4, n, z, v, c}.
    function automatic logic [24:0] model(input logic [2:0] op, input logic [15:0] a,
                                          input logic [15:0] m, input logic [4:0] cc);
        logic [15:0] r = '0;
        logic we = 1'b0;
        logic [3:0] upd = 4'h0;
        logic n = cc[3], z = cc[2], v = cc[1], c = cc[0];
        logic [7:0] r8;
        int d, lo, t, corr;
        logic hi;
        case (op)
            3'd0: begin r = 0; we = 1; upd = 4'hF; n = 0; z = 1; v = 0; c = 0; end
            3'd1: begin r8 = 8'hFF - a[7:0]; r = {8'h0, r8}; we = 1; upd = 4'hF;
                        n = r8[7]; z = (r8 == 0); v = 0; c = 1; end
            3'd2: begin r8 = a[7:0] - 8'd1; r = {8'h0, r8}; we = 1; upd = 4'hE;
                        n = r8[7]; z = (r8 == 0); v = (a[7:0] == 8'h80); end
            3'd3: begin r8 = a[7:0] ^ m[7:0]; r = {8'h0, r8}; we = 1; upd = 4'hE;
                        n = r8[7]; z = (r8 == 0); v = 0; end
            3'd4: begin r8 = a[7:0] - m[7:0]; r = {8'h0, r8}; upd = 4'hF;
                        d = int'($signed(a[7:0])) - int'($signed(m[7:0]));
                        n = r8[7]; z = (r8 == 0); v = (d < -128 || d > 127); c = (a[7:0] < m[7:0]); end
            3'd5: begin r = a - m; upd = 4'hF;
                        d = int'($signed(a)) - int'($signed(m));
                        n = r[15]; z = (r == 0); v = (d < -32768 || d > 32767); c = (a < m); end
            3'd6: begin
                lo = int'(a[3:0]); corr = 0;
                if (lo > 9 || cc[4]) corr = 6;
                t = int'(a[7:0]) + corr;
                hi = ((t / 16) > 9) || cc[0];
                if (hi) corr = corr + 96;
                r8 = 8'((int'(a[7:0]) + corr) % 256);
                r = {8'h0, r8}; we = 1; upd = 4'hF;
                n = r8[7]; z = (r8 == 0); v = !a[7] && r8[7]; c = cc[0] || hi;
            end
            default: begin r = 0; end
        endcase
        return {r, we, upd, n, z, v, c};
    endfunction

    // Drive on the falling edge, compare a quarter period later.
    task automatic run_vec(input logic [2:0] op, input logic [15:0] a, input logic [15:0] m,
                           input logic [4:0] cc, input string req);
        logic [24:0] exp_v, act_v;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_m = m; cc_in = cc;
        #(CLK_PERIOD/4);
        exp_v = model(op, a, m, cc);
        act_v = {result, res_we, flag_upd, n_out, z_out, v_out, c_out};
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s op=%0d a=%h m=%h cc=%b actual=%h expected=%h",
                     req, op, a, m, cc, act_v, exp_v);
        end
    endtask

    task automatic t_idle;   // R10 R1: quiescent state after reset
        run_vec(3'd7, 16'h0000, 16'h0000, 5'b00000, "R10");
        run_vec(3'd7, 16'h1234, 16'hFFFF, 5'b11111, "R10");
    endtask

    task automatic t_clear;  // R2
        run_vec(3'd0, 16'hAB55, 16'h0000, 5'b01011, "R2");
        run_vec(3'd0, 16'h00FF, 16'h1111, 5'b10000, "R2");
    endtask

    task automatic t_com;    // R3 R1
        run_vec(3'd1, 16'hFF00, 16'h0000, 5'b00100, "R3");
        run_vec(3'd1, 16'h00FF, 16'h0000, 5'b00000, "R3");
        run_vec(3'd1, 16'h775A, 16'h0000, 5'b00010, "R1");
    endtask

    task automatic t_dec;    // R4 R11
        run_vec(3'd2, 16'h0080, 16'h0000, 5'b00000, "R4");
        run_vec(3'd2, 16'h0001, 16'h0000, 5'b00001, "R4");
        run_vec(3'd2, 16'hFF00, 16'h0000, 5'b00001, "R11");
        run_vec(3'd2, 16'h0000, 16'h0000, 5'b00000, "R4");
    endtask

    task automatic t_xor;    // R5 R11
        run_vec(3'd3, 16'h00A5, 16'h00A5, 5'b00011, "R5");
        run_vec(3'd3, 16'h000F, 16'h00F0, 5'b00010, "R5");
        run_vec(3'd3, 16'h3C00, 16'hC301, 5'b00001, "R11");
    endtask

    task automatic t_cmp8;   // R6
        run_vec(3'd4, 16'h0042, 16'h0042, 5'b00000, "R6");
        run_vec(3'd4, 16'h0010, 16'h0020, 5'b00000, "R6");
        run_vec(3'd4, 16'h0080, 16'h0001, 5'b00000, "R6");
        run_vec(3'd4, 16'h007F, 16'h00FF, 5'b01111, "R6");
        run_vec(3'd4, 16'hAA05, 16'h5503, 5'b00000, "R1");
    endtask

    task automatic t_cmp16;  // R7
        run_vec(3'd5, 16'h8000, 16'h0001, 5'b00000, "R7");
        run_vec(3'd5, 16'h1234, 16'h1234, 5'b00000, "R7");
        run_vec(3'd5, 16'h0000, 16'h0001, 5'b00000, "R7");
        run_vec(3'd5, 16'h0100, 16'h00FF, 5'b01111, "R7");
        run_vec(3'd5, 16'h7FFF, 16'hFFFF, 5'b00000, "R7");
    endtask

    task automatic t_daa;    // R8 R9
        run_vec(3'd6, 16'h009A, 16'h0000, 5'b00000, "R8");
        run_vec(3'd6, 16'h000F, 16'h0000, 5'b00000, "R8");
        run_vec(3'd6, 16'h0042, 16'h0000, 5'b10000, "R8");
        run_vec(3'd6, 16'h00FA, 16'h0000, 5'b00000, "R9");
        run_vec(3'd6, 16'h0012, 16'h0000, 5'b00001, "R9");
        run_vec(3'd6, 16'h0099, 16'h0000, 5'b00000, "R9");
        run_vec(3'd6, 16'h007A, 16'h0000, 5'b00000, "R9");
    endtask

    task automatic t_sweep;  // R12 R13: every code over several patterns
        for (int op = 0; op < 8; op++) begin
            for (int k = 0; k < 6; k++) begin
                run_vec(3'(op), 16'(k * 16'h2B47 + 16'h0913), 16'(k * 16'h5D21 + 16'h0380),
                        5'(k * 7), "R12");
            end
        end
    endtask

    // Watchdog: a hang counts as a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R13 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_clear();
        t_com();
        t_dec();
        t_xor();
        t_cmp8();
        t_cmp16();
        t_daa();
        t_sweep();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule